// File: doc/BRIEF.md
# Two-Level Translation Walker

This block runs on a translation-cache miss. It turns a virtual address into a physical frame by reading a two-level table tree in memory. A request carries the virtual address and the physical base of the top-level (directory) table. The walker splits the virtual address into three fields:

- a directory index in bits 31:22;
- a leaf index in bits 21:12;
- a 12-bit page offset.

It reads the directory slot at `root + dir_index*4`. If that slot is present, it reads the leaf slot at `{dir_slot[31:12], 12'h000} + leaf_index*4`. It then returns the frame number, the leaf flag bits and the joined physical address, which the translation cache uses for its fill. In each 32-bit table slot, bit 0 is the present bit and bits 31:12 hold the next-table base or the frame number.

A directory slot that is not present ends the walk at once with a level-0 fault, and no leaf read is issued. A leaf slot that is not present gives a level-1 fault. Only one walk runs at a time, and `busy` refuses new requests while it runs. The memory side is a plain read port: a one-cycle request strobe, then a response strobe after any number of cycles.

The control is one state machine with these transitions:

- S_IDLE → S_DIR_ISSUE when a request is accepted.
- S_DIR_ISSUE → S_DIR_WAIT unconditionally.
- S_DIR_WAIT → S_LEAF_ISSUE when the returned slot is present.
- S_DIR_WAIT → S_FAULT when the returned slot is absent.
- S_LEAF_ISSUE → S_LEAF_WAIT unconditionally.
- S_LEAF_WAIT → S_DONE when the returned slot is present.
- S_LEAF_WAIT → S_FAULT when the returned slot is absent.
- S_DONE → S_IDLE and S_FAULT → S_IDLE unconditionally.

Top module: `ptw_top`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `rsp_valid` and `mem_rd_en` are 0.
- R2: The first read of a walk is issued in the cycle after acceptance, at address `root + vaddr[31:22]*4`.
- R3: The second read address is `{dir_slot[31:12], 12'h000} + vaddr[21:12]*4`, so the low 12 bits of the directory slot are ignored.
- R4: A walk whose two slots are both present responds with `rsp_fault`=0, `rsp_frame`=leaf[31:12], `rsp_flags`=leaf[11:0] and `rsp_paddr`={leaf[31:12], vaddr[11:0]}.
- R5: A directory slot with bit 0 = 0 ends the walk with `rsp_fault`=1 and `rsp_fault_lvl`=0, after exactly one memory read.
- R6: A leaf slot with bit 0 = 0 ends the walk with `rsp_fault`=1 and `rsp_fault_lvl`=1, after exactly two memory reads.
- R7: `busy` is 1 from the cycle after acceptance through the response cycle, and 0 in the cycle after. A `req_valid` seen while `busy` is 1 neither changes the result nor starts a further walk.
- R8: `mem_rd_en` is high for exactly one cycle per read. `rsp_valid` is a single-cycle pulse, once per walk, for any response latency of one cycle or more.
- R9: A `mem_rd_valid` seen in any state other than a wait state is ignored. This covers idle and the cycle that issues a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request, accepted when `busy` is 0 |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Physical base of the directory table |
| busy | output | 1 | A walk is in progress |
| mem_rd_en | output | 1 | One-cycle memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the table slot being read |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 32 | Table slot returned by memory |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended on an absent slot |
| rsp_fault_lvl | output | 1 | Level that faulted: 0 directory, 1 leaf |
| rsp_frame | output | 20 | Frame number of the translation |
| rsp_flags | output | 12 | Low 12 bits of the leaf slot |
| rsp_paddr | output | 32 | Frame joined with the page offset |

## Verification
The hardest cases to reach from the ports are a response strobe that lands in an issue cycle, and a second request that arrives while a walk is still running. The bench plays the memory itself. On selected walks it fires a bogus, absent-looking response in the very cycle `mem_rd_en` is seen, and sends the real data only later. On other walks it holds `req_valid` high with a different address for the whole walk. It then confirms that the original translation comes back and that `busy` drops and stays low afterwards.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_ISSUE,
        S_DIR_WAIT,
        S_LEAF_ISSUE,
        S_LEAF_WAIT,
        S_DONE,
        S_FAULT
    } walk_state_e;

    typedef enum logic {
        LVL_DIR  = 1'b0,
        LVL_LEAF = 1'b1
    } walk_level_e;

endpackage

// File: rtl/ptw_slot_addr.sv
// Byte address of one table slot: base plus scaled index.
module ptw_slot_addr #(
    parameter int PA_W        = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - IDX_W;

    logic [PA_W-1:0] idx_wide;

    always_comb begin
        idx_wide = {{PAD_W{1'b0}}, idx} << ENTRY_SHIFT;
        addr     = base + idx_wide;
    end
endmodule

// File: rtl/ptw_entry_fields.sv
// Splits a table slot into present bit, next-level base, frame and flags.
module ptw_entry_fields #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [PA_W-1:0]       entry,
    output logic                  present,
    output logic [PA_W-1:0]       next_base,
    output logic [PA_W-OFF_W-1:0] frame,
    output logic [OFF_W-1:0]      flags
);
    always_comb begin
        present   = entry[0];
        frame     = entry[PA_W-1:OFF_W];
        next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        flags     = entry[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int LEAF_IDX_W  = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       req_root,
    output logic                  busy,
    output logic                  mem_rd_en,
    output logic [PA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [PA_W-1:0]       mem_rd_data,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic                  rsp_fault_lvl,
    output logic [PA_W-OFF_W-1:0] rsp_frame,
    output logic [OFF_W-1:0]      rsp_flags,
    output logic [PA_W-1:0]       rsp_paddr
);
    import ptw_pkg::*;

    localparam int DIR_IDX_W   = VA_W - OFF_W - LEAF_IDX_W;
    localparam int FRAME_W     = PA_W - OFF_W;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int IDX_MAX_W   = (DIR_IDX_W > LEAF_IDX_W) ? DIR_IDX_W : LEAF_IDX_W;

    walk_state_e          state_q, state_d;
    walk_level_e          lvl_q;
    logic [VA_W-1:0]      va_q;
    logic [PA_W-1:0]      root_q;
    logic [PA_W-1:0]      tbl_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [OFF_W-1:0]     flags_q;

    logic [PA_W-1:0]      sel_base;
    logic [IDX_MAX_W-1:0] sel_idx;
    logic [PA_W-1:0]      slot_addr;
    logic                 ent_present;
    logic [PA_W-1:0]      ent_base;
    logic [FRAME_W-1:0]   ent_frame;
    logic [OFF_W-1:0]     ent_flags;

    // Address source: directory fields until the leaf read is issued.
    always_comb begin
        if (state_q == S_LEAF_ISSUE) begin
            sel_base = tbl_q;
            sel_idx  = IDX_MAX_W'(va_q[OFF_W +: LEAF_IDX_W]);
        end else begin
            sel_base = root_q;
            sel_idx  = IDX_MAX_W'(va_q[VA_W-1 -: DIR_IDX_W]);
        end
    end

    ptw_slot_addr #(
        .PA_W        (PA_W),
        .IDX_W       (IDX_MAX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) slot_addr_i (
        .base (sel_base),
        .idx  (sel_idx),
        .addr (slot_addr)
    );

    ptw_entry_fields #(
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) entry_fields_i (
        .entry     (mem_rd_data),
        .present   (ent_present),
        .next_base (ent_base),
        .frame     (ent_frame),
        .flags     (ent_flags)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_valid) state_d = S_DIR_ISSUE;
            S_DIR_ISSUE:  state_d = S_DIR_WAIT;
            S_DIR_WAIT:   if (mem_rd_valid) state_d = ent_present ? S_LEAF_ISSUE : S_FAULT;
            S_LEAF_ISSUE: state_d = S_LEAF_WAIT;
            S_LEAF_WAIT:  if (mem_rd_valid) state_d = ent_present ? S_DONE : S_FAULT;
            S_DONE:       state_d = S_IDLE;
            S_FAULT:      state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // Walk context and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            root_q  <= '0;
            tbl_q   <= '0;
            frame_q <= '0;
            flags_q <= '0;
            lvl_q   <= LVL_DIR;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        root_q <= req_root;
                    end
                end
                S_DIR_WAIT: begin
                    if (mem_rd_valid) begin
                        tbl_q <= ent_base;
                        lvl_q <= LVL_DIR;
                    end
                end
                S_LEAF_WAIT: begin
                    if (mem_rd_valid) begin
                        frame_q <= ent_frame;
                        flags_q <= ent_flags;
                        lvl_q   <= LVL_LEAF;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != S_IDLE);
        mem_rd_en     = (state_q == S_DIR_ISSUE) || (state_q == S_LEAF_ISSUE);
        mem_rd_addr   = slot_addr;
        rsp_valid     = (state_q == S_DONE) || (state_q == S_FAULT);
        rsp_fault     = (state_q == S_FAULT);
        rsp_fault_lvl = lvl_q;
        rsp_frame     = frame_q;
        rsp_flags     = flags_q;
        rsp_paddr     = {frame_q, va_q[OFF_W-1:0]};
    end
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [OFF_W-1:0]      req_off,
    input logic                  busy,
    input logic                  mem_rd_en,
    input logic                  rsp_valid,
    input logic                  rsp_fault,
    input logic                  rsp_fault_lvl,
    input logic [PA_W-OFF_W-1:0] rsp_frame,
    input logic [PA_W-1:0]       rsp_paddr
);
    logic             accept;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       rd_cnt;

    assign accept = req_valid && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            rd_cnt <= '0;
        end else if (accept) begin
            off_q  <= req_off;
            rd_cnt <= '0;
        end else if (mem_rd_en && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    p_idle_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);
    p_read_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_read_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);
    p_paddr_join_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
            (rsp_paddr == {rsp_frame, off_q}));
    p_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rd_cnt == 2'd2));
    p_dir_fault_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_lvl) |-> (rd_cnt == 2'd1));
    p_leaf_fault_two_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_fault_lvl) |-> (rd_cnt == 2'd2));
endmodule

bind ptw_top ptw_top_chk #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .busy          (busy),
    .mem_rd_en     (mem_rd_en),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_frame     (rsp_frame),
    .rsp_paddr     (rsp_paddr)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic [31:0] dir;
        logic [31:0] leaf;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0040_1ABC, 32'h0001_0000, 32'h0002_0001, 32'h1234_5067, 4'd0},
        '{32'hFFFF_FFFF, 32'h0003_0000, 32'hABCD_E0F1, 32'h0000_1003, 4'd3},
        '{32'h0000_0000, 32'h0004_0000, 32'h0005_0000, 32'h0000_0001, 4'd2},
        '{32'h8020_3FFF, 32'h0005_0000, 32'h0006_0003, 32'h7777_7FFE, 4'd0},
        '{32'h1234_5678, 32'h0007_F000, 32'hFFFF_F001, 32'hFFFF_FFFF, 4'd5},
        '{32'h003F_F000, 32'h0000_0000, 32'h0000_1001, 32'h0000_0001, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        busy;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic        rsp_fault_lvl;
    logic [19:0] rsp_frame;
    logic [11:0] rsp_flags;
    logic [31:0] rsp_paddr;

    int n_checks = 0;
    int n_errs   = 0;

    always #10 clk = ~clk;

    ptw_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .busy          (busy),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_data   (mem_rd_data),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl),
        .rsp_frame     (rsp_frame),
        .rsp_flags     (rsp_flags),
        .rsp_paddr     (rsp_paddr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input vec_t v, input bit disturb, input bit spurious,
                            input string tag);
        logic [31:0] exp_dir_addr;
        logic [31:0] exp_leaf_addr;
        bit          exp_fault;
        bit          got;
        bit          busy_bad;
        int          exp_reads;
        int          nrd;
        int          cd;
        exp_dir_addr  = v.root + {20'h0, v.va[31:22], 2'b00};
        exp_leaf_addr = {v.dir[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
        exp_fault     = !v.dir[0] || !v.leaf[0];
        exp_reads     = v.dir[0] ? 2 : 1;
        got = 1'b0; busy_bad = 1'b0; nrd = 0; cd = -1;

        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_root  = v.root;

        for (int c = 0; c < 80 && !got; c++) begin
            @(negedge clk);
            if (rsp_valid) begin
                got = 1'b1;
                check("R7", {tag, " busy in response cycle"}, {31'h0, busy}, 32'h1);
                if (!v.dir[0]) begin
                    check("R5", {tag, " fault"}, {31'h0, rsp_fault}, 32'h1);
                    check("R5", {tag, " fault level"}, {31'h0, rsp_fault_lvl}, 32'h0);
                end else if (!v.leaf[0]) begin
                    check("R6", {tag, " fault"}, {31'h0, rsp_fault}, 32'h1);
                    check("R6", {tag, " fault level"}, {31'h0, rsp_fault_lvl}, 32'h1);
                end else begin
                    check("R4", {tag, " fault"}, {31'h0, rsp_fault}, 32'h0);
                    check("R4", {tag, " frame"}, {12'h0, rsp_frame}, {12'h0, v.leaf[31:12]});
                    check("R4", {tag, " flags"}, {20'h0, rsp_flags}, {20'h0, v.leaf[11:0]});
                    check("R4", {tag, " paddr"}, rsp_paddr, {v.leaf[31:12], v.va[11:0]});
                end
            end else begin
                if (!busy) busy_bad = 1'b1;
                if (mem_rd_en) begin
                    nrd++;
                    if (nrd == 1)
                        check("R2", {tag, " directory read address"}, mem_rd_addr, exp_dir_addr);
                    else if (nrd == 2)
                        check("R3", {tag, " leaf read address"}, mem_rd_addr, exp_leaf_addr);
                    cd = int'(v.lat) + 1;
                end
            end
            // drive inputs for the next edge
            req_valid    = disturb && !got;
            req_vaddr    = disturb ? ~v.va : v.va;
            req_root     = disturb ? ~v.root : v.root;
            mem_rd_valid = 1'b0;
            mem_rd_data  = 32'h0;
            if (!got) begin
                if (cd == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = (nrd == 1) ? v.dir : v.leaf;
                    cd = -1;
                end else if (cd > 0) begin
                    if (spurious && cd == int'(v.lat) + 1) begin
                        mem_rd_valid = 1'b1;   // R9: lands in the issue cycle
                        mem_rd_data  = 32'h0;
                    end
                    cd--;
                end
            end
        end

        check("R8", {tag, " response seen"}, {31'h0, got}, 32'h1);
        check("R7", {tag, " busy held during walk"}, {31'h0, busy_bad}, 32'h0);
        check("R8", {tag, " read count"}, nrd, exp_reads);
        exp_fault = exp_fault;
        req_valid = 1'b0;
        mem_rd_valid = 1'b0;
        @(negedge clk);
        check("R8", {tag, " response is one pulse"}, {31'h0, rsp_valid}, 32'h0);
        check("R7", {tag, " idle after response"}, {31'h0, busy}, 32'h0);
        if (disturb) begin
            @(negedge clk);
            check("R7", {tag, " no walk from blocked request"}, {30'h0, busy, mem_rd_en}, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL R8 watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", {31'h0, busy}, 32'h0);
        check("R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        check("R1", "mem_rd_en in reset", {31'h0, mem_rd_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "outputs after reset", {29'h0, busy, rsp_valid, mem_rd_en}, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            run_walk(VECS[i], 1'b0, 1'b0, $sformatf("vec%0d", i));
        end

        // R7: requests held high during a walk are refused
        run_walk(VECS[0], 1'b1, 1'b0, "blocked-req valid");
        run_walk(VECS[2], 1'b1, 1'b0, "blocked-req dir fault");

        // R9: stray response while idle
        @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        check("R9", "stray response while idle",
              {29'h0, busy, rsp_valid, mem_rd_en}, 32'h0);
        mem_rd_valid = 1'b0;

        // R9: stray response in the issue cycles
        run_walk(VECS[1], 1'b0, 1'b1, "stray-in-issue valid");
        run_walk(VECS[3], 1'b0, 1'b1, "stray-in-issue leaf fault");

        // Back-to-back walks
        run_walk(VECS[4], 1'b0, 1'b0, "b2b first");
        run_walk(VECS[5], 1'b0, 1'b0, "b2b second");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule